// File: doc/BRIEF.md
# Pipelined Salsa20 Hash Core

This block computes the Salsa20 hash at full rate. Every clock cycle it can take a new 128-bit word (nonce and block counter) together with a 256-bit key. It builds the 16-word starting state from these and sends that state down a chain of registered round stages. Each stage holds two lanes. One lane carries the starting state unchanged. The other lane carries the state as the rounds transform it. After the last stage, the two lanes are added word by word to form the 512-bit hash. One result leaves per cycle, in input order, a fixed number of cycles after its input entered.

The default chain has twenty stages, which alternate between a column round and a row round. With `STAGES = 10` each stage instead applies a full double round. This halves the latency and gives the same hash values. A valid flag travels alongside the data. The block has no stall path: a caller that cannot take a result must buffer it outside the block.

Top module: `salsa_pipe_core`

## Requirements
- R1: The starting state uses these words. Words 0, 5, 10 and 15 hold the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Words 1–4 hold `in_key[127:0]` and words 11–14 hold `in_key[255:128]`, with the lowest 32 bits going to the lowest word in each case. Words 6–9 hold `in_data`, laid out the same way.
- R2: The round part is ten double rounds. Each double round is a column round followed by a row round. The quarter rounds use left rotations of 7, 9, 13 and 18.
- R3: Word i of the result sits at `hash_out[32*i +: 32]`. It equals the sum, modulo 2^32, of starting word i and final round word i.
- R4: The block accepts a new input on every cycle with no gap. Results leave in the same order as their inputs.
- R5: With the default depth, `hash_valid` equals `in_valid` delayed by exactly 20 cycles.
- R6: A cycle with `in_valid` low produces a cycle with `hash_valid` low exactly one latency later. Gaps in the input stream are kept in the output stream.
- R7: Each hash uses the key that was presented in the same cycle as its input word. The key may change on every cycle.
- R8: `rst_n` is a synchronous, active-low reset. After a clock edge with `rst_n` low, `hash_out` is all zero and `hash_valid` is low. Inputs that were in flight at that edge never appear at the output.
- R9: With `STAGES = 10`, each stage applies a full double round. `hash_valid` then lags `in_valid` by exactly 10 cycles, and the hash values are the same as with the default depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_data`/`in_key` as a real input this cycle |
| in_data | input | 128 | Nonce and block counter words |
| in_key | input | 256 | Key words |
| hash_out | output | 512 | Sixteen result words, word 0 in the low bits |
| hash_valid | output | 1 | Marks `hash_out` as a real result |

## Verification
The bench compares every output against an independent model that uses a written-out table of quarter-round indices. Any misplaced index, wrong rotation or swapped column/row order therefore corrupts every hash. The bench streams inputs back to back with a new key on every cycle. A design that latched the key late, or that held the starting state one stage out of step, would then pair a hash with its neighbour's key. Patterns with gaps and a single isolated pulse test the valid timing: a shift chain one cycle too short or too long would fail in every cycle around each edge. A reset in the middle of a stream, with `in_valid` held high during the reset cycle, catches a design whose reset misses a lane or lets in-flight work leak out. The ten-stage variant runs alongside the default one on the same stimulus.

// File: rtl/salsa_pkg.sv
// Shared types and pure round functions for the pipelined Salsa20 core.
// Assumes words are 32 bits, with state word i at bits [32*i +: 32].
package salsa_pkg;

    typedef logic [31:0]       word_t;
    typedef logic [15:0][31:0] state_t;
    typedef logic [3:0]        widx_t;

    // Selects the work that one pipeline stage performs.
    typedef enum logic [1:0] {
        RND_COLUMN = 2'd0,
        RND_ROW    = 2'd1,
        RND_DOUBLE = 2'd2
    } rnd_kind_e;

    localparam word_t SIGMA0 = 32'h6170_7865;
    localparam word_t SIGMA1 = 32'h3320_646e;
    localparam word_t SIGMA2 = 32'h7962_2d32;
    localparam word_t SIGMA3 = 32'h6b20_6574;

    localparam int unsigned ROT_A = 7;
    localparam int unsigned ROT_B = 9;
    localparam int unsigned ROT_C = 13;
    localparam int unsigned ROT_D = 18;

    // Left rotation of a 32-bit word.
    function automatic word_t rotl(input word_t w, input int unsigned n);
        rotl = (w << n) | (w >> (32 - n));
    endfunction

    // One quarter round on the words at positions a, b, c and d.
    function automatic state_t quarter(input state_t s, input widx_t a,
                                       input widx_t b, input widx_t c,
                                       input widx_t d);
        state_t r;
        r    = s;
        r[b] = r[b] ^ rotl(r[a] + r[d], ROT_A);
        r[c] = r[c] ^ rotl(r[b] + r[a], ROT_B);
        r[d] = r[d] ^ rotl(r[c] + r[b], ROT_C);
        r[a] = r[a] ^ rotl(r[d] + r[c], ROT_D);
        quarter = r;
    endfunction

    // Column round. Column c starts on the diagonal word 5c and steps down by 4 (mod 16).
    function automatic state_t column_round(input state_t s);
        state_t r;
        widx_t  base;
        r = s;
        for (int c = 0; c < 4; c++) begin
            base = widx_t'(5 * c);
            r = quarter(r, base, base + widx_t'(4), base + widx_t'(8),
                        base + widx_t'(12));
        end
        column_round = r;
    endfunction

    // Row round. Row c starts on its diagonal word and wraps within the row.
    function automatic state_t row_round(input state_t s);
        state_t r;
        widx_t  row;
        r = s;
        for (int c = 0; c < 4; c++) begin
            row = widx_t'(4 * c);
            r = quarter(r, row + widx_t'(c % 4), row + widx_t'((c + 1) % 4),
                        row + widx_t'((c + 2) % 4), row + widx_t'((c + 3) % 4));
        end
        row_round = r;
    endfunction

    // Double round: a column round, then a row round.
    function automatic state_t double_round(input state_t s);
        double_round = row_round(column_round(s));
    endfunction

endpackage

// File: rtl/salsa_init.sv
// Builds the 16-word starting state from the key and the 128-bit input word.
// Purely combinational. Assumes the caller registers the result.
module salsa_init
    import salsa_pkg::*;
(
    input  logic [255:0] key,
    input  logic [127:0] nonce_ctr,
    output state_t       st
);

    localparam int unsigned KEY_HALF = 4;

    // Place the constants, the two key halves and the input words.
    always_comb begin
        st     = '0;
        st[0]  = SIGMA0;
        st[5]  = SIGMA1;
        st[10] = SIGMA2;
        st[15] = SIGMA3;
        for (int i = 0; i < KEY_HALF; i++) begin
            st[1 + i]  = key[32 * i +: 32];
            st[11 + i] = key[128 + 32 * i +: 32];
            st[6 + i]  = nonce_ctr[32 * i +: 32];
        end
    end

endmodule

// File: rtl/salsa_stage.sv
// One registered pipeline stage with two lanes. The carry lane copies the
// starting state unchanged. The work lane applies the round chosen by KIND.
// A valid bit moves in step with both lanes. Assumes a synchronous active-low reset.
module salsa_stage
    import salsa_pkg::*;
#(
    parameter rnd_kind_e KIND = RND_COLUMN
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   vld_in,
    input  state_t orig_in,
    input  state_t work_in,
    output logic   vld_q,
    output state_t orig_q,
    output state_t work_q
);

    state_t work_nxt;

    // Pick the round function for this stage at elaboration time.
    generate
        if (KIND == RND_COLUMN) begin : g_col
            assign work_nxt = column_round(work_in);
        end else if (KIND == RND_ROW) begin : g_row
            assign work_nxt = row_round(work_in);
        end else begin : g_dbl
            assign work_nxt = double_round(work_in);
        end
    endgenerate

    // Register both lanes and the valid bit; clear all of them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            orig_q <= '0;
            work_q <= '0;
        end else begin
            vld_q  <= vld_in;
            orig_q <= orig_in;
            work_q <= work_nxt;
        end
    end

    // R3: the carry lane must copy the starting state exactly, one cycle later.
    a_r3_carry_lane_copies: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (orig_q == $past(orig_in)));

    // R5: the valid bit moves forward exactly one stage per cycle.
    a_r5_valid_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_q == $past(vld_in)));

endmodule

// File: rtl/salsa_feedfwd.sv
// Final feed-forward: word-wise modulo-2^32 sum of the carried starting state
// and the last round result. Combinational. It adds no latency.
module salsa_feedfwd
    import salsa_pkg::*;
(
    input  state_t orig,
    input  state_t work,
    output state_t sum
);

    // Add each pair of words; the carry out of bit 31 is dropped.
    always_comb begin
        for (int i = 0; i < 16; i++) begin
            sum[i] = orig[i] + work[i];
        end
    end

endmodule

// File: rtl/salsa_pipe_core.sv
// Fully pipelined Salsa20 hash. It accepts one input per cycle and returns one
// 512-bit hash per cycle, STAGES cycles later. STAGES = 20 alternates column
// and row stages. STAGES = 10 uses one double round per stage. No other depth
// is supported. Assumes a synchronous active-low reset and no backpressure.
module salsa_pipe_core
    import salsa_pkg::*;
#(
    parameter int unsigned STAGES = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [127:0] in_data,
    input  logic [255:0] in_key,
    output logic [511:0] hash_out,
    output logic         hash_valid
);

    localparam bit FULL_DR = (STAGES == 10);

    state_t init_st;
    state_t sum_st;
    logic   vld_c  [STAGES + 1];
    state_t orig_c [STAGES + 1];
    state_t work_c [STAGES + 1];

    // Build the starting state in front of the first stage.
    salsa_init u_init (
        .key      (in_key),
        .nonce_ctr(in_data),
        .st       (init_st)
    );

    // Both lanes of the first stage start from the same state.
    assign vld_c[0]  = in_valid;
    assign orig_c[0] = init_st;
    assign work_c[0] = init_st;

    // Chain of stages. Even positions do column rounds and odd positions do row rounds.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            localparam rnd_kind_e K = FULL_DR ? RND_DOUBLE :
                                      ((g % 2 == 0) ? RND_COLUMN : RND_ROW);
            salsa_stage #(.KIND(K)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .vld_in (vld_c[g]),
                .orig_in(orig_c[g]),
                .work_in(work_c[g]),
                .vld_q  (vld_c[g + 1]),
                .orig_q (orig_c[g + 1]),
                .work_q (work_c[g + 1])
            );
        end
    endgenerate

    // Add the carried starting state back after the last stage.
    salsa_feedfwd u_ff (
        .orig(orig_c[STAGES]),
        .work(work_c[STAGES]),
        .sum (sum_st)
    );

    assign hash_out   = sum_st;
    assign hash_valid = vld_c[STAGES];

    // R8: a reset edge leaves the output zero and not valid.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (hash_valid == 1'b0 && hash_out == '0));

    // R1: a valid result still carries the four constant words at the end of the chain.
    a_r1_sigma_carried: assert property (@(posedge clk) disable iff (!rst_n)
        hash_valid |-> (orig_c[STAGES][0] == SIGMA0 && orig_c[STAGES][5] == SIGMA1 &&
                        orig_c[STAGES][10] == SIGMA2 && orig_c[STAGES][15] == SIGMA3));

endmodule

// File: tb/tb_salsa_pipe_core.sv
// Directed bench for salsa_pipe_core. It runs the 20-stage and 10-stage builds side by side on the same stimulus.
module tb_salsa_pipe_core;

    localparam int NMAX = 48;
    localparam int LAT_A = 20;
    localparam int LAT_B = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_data;
    logic [255:0] in_key;
    logic [511:0] hash_out, hash_out10;
    logic         hash_valid, hash_valid10;

    int n_tot = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic         s_vld [NMAX];
    logic [127:0] s_in  [NMAX];
    logic [255:0] s_key [NMAX];
    logic [511:0] s_exp [NMAX];
    logic [31:0]  rs = 32'h1357_9bdf;

    int cq [4][4] = '{'{0, 4, 8, 12}, '{5, 9, 13, 1}, '{10, 14, 2, 6}, '{15, 3, 7, 11}};
    int rq [4][4] = '{'{0, 1, 2, 3}, '{5, 6, 7, 4}, '{10, 11, 8, 9}, '{15, 12, 13, 14}};

    always #10 clk = ~clk;

    salsa_pipe_core #(.STAGES(20)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_key(in_key), .hash_out(hash_out), .hash_valid(hash_valid));

    salsa_pipe_core #(.STAGES(10)) dut10 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_key(in_key), .hash_out(hash_out10), .hash_valid(hash_valid10));

    function automatic logic [31:0] rol(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    // Reference model: table-driven quarter rounds applied to a copy of the state.
    function automatic logic [511:0] ref_hash(input logic [255:0] k, input logic [127:0] n);
        logic [31:0] x [16];
        logic [31:0] z [16];
        logic [511:0] r;
        int a, b, c, d;
        x[0] = 32'h61707865; x[5] = 32'h3320646e; x[10] = 32'h79622d32; x[15] = 32'h6b206574;
        for (int i = 0; i < 4; i++) begin
            x[1 + i]  = k[32 * i +: 32];
            x[11 + i] = k[128 + 32 * i +: 32];
            x[6 + i]  = n[32 * i +: 32];
        end
        z = x;
        for (int dr = 0; dr < 10; dr++) begin
            for (int h = 0; h < 8; h++) begin
                a = (h < 4) ? cq[h][0] : rq[h - 4][0];
                b = (h < 4) ? cq[h][1] : rq[h - 4][1];
                c = (h < 4) ? cq[h][2] : rq[h - 4][2];
                d = (h < 4) ? cq[h][3] : rq[h - 4][3];
                z[b] = z[b] ^ rol(z[a] + z[d], 7);
                z[c] = z[c] ^ rol(z[b] + z[a], 9);
                z[d] = z[d] ^ rol(z[c] + z[b], 13);
                z[a] = z[a] ^ rol(z[d] + z[c], 18);
            end
        end
        for (int i = 0; i < 16; i++) r[32 * i +: 32] = x[i] + z[i];
        return r;
    endfunction

    function automatic logic [31:0] next_rand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic logic [127:0] rand128();
        return {next_rand(), next_rand(), next_rand(), next_rand()};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Drive s_* entries 0..n-1 on consecutive cycles and check both builds on every cycle.
    task automatic run_seq(input int n, input string req);
        int j;
        logic ev;
        for (int t = 0; t <= n + LAT_A; t++) begin
            @(negedge clk);
            j  = t - LAT_A;
            ev = (j >= 0 && j < n) ? s_vld[j] : 1'b0;
            chk(hash_valid == ev, {req, " R5 valid timing (20)"}, 512'(hash_valid), 512'(ev));
            if (ev) chk(hash_out == s_exp[j], {req, " R2 R3 hash (20)"}, hash_out, s_exp[j]);
            j  = t - LAT_B;
            ev = (j >= 0 && j < n) ? s_vld[j] : 1'b0;
            chk(hash_valid10 == ev, {req, " R9 valid timing (10)"}, 512'(hash_valid10), 512'(ev));
            if (ev) chk(hash_out10 == s_exp[j], {req, " R9 hash (10)"}, hash_out10, s_exp[j]);
            if (t < n) begin
                in_valid = s_vld[t];
                in_data  = s_in[t];
                in_key   = s_key[t];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    // R8: while reset is held, both builds show zero and not valid.
    task automatic t_reset_state();
        @(negedge clk);
        chk(hash_valid == 1'b0, "R8 reset valid", 512'(hash_valid), 512'(0));
        chk(hash_out == '0, "R8 reset data", hash_out, '0);
        chk(hash_valid10 == 1'b0, "R8 reset valid (10)", 512'(hash_valid10), 512'(0));
        chk(hash_out10 == '0, "R8 reset data (10)", hash_out10, '0);
    endtask

    // R5 R9: one isolated pulse appears exactly one latency later.
    task automatic t_single();
        s_vld[0] = 1'b1; s_in[0] = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        s_key[0] = {rand128(), rand128()};
        s_exp[0] = ref_hash(s_key[0], s_in[0]);
        run_seq(1, "single");
    endtask

    // R1: all-zero and all-ones key/input still match the layout model.
    task automatic t_extremes();
        s_vld[0] = 1'b1; s_in[0] = '0; s_key[0] = '0;
        s_vld[1] = 1'b1; s_in[1] = '1; s_key[1] = '1;
        s_vld[2] = 1'b1; s_in[2] = '0; s_key[2] = {128'h0, {4{32'hffff_ffff}}};
        for (int i = 0; i < 3; i++) s_exp[i] = ref_hash(s_key[i], s_in[i]);
        run_seq(3, "R1 extremes");
    endtask

    // R4 R7: back-to-back inputs with a fresh key on every cycle.
    task automatic t_stream();
        for (int i = 0; i < 32; i++) begin
            s_vld[i] = 1'b1;
            s_in[i]  = rand128();
            s_key[i] = {rand128(), rand128()};
            s_exp[i] = ref_hash(s_key[i], s_in[i]);
        end
        run_seq(32, "R4 R7 stream");
    endtask

    // R6: gaps in the input pattern are kept at the output.
    task automatic t_bubbles();
        for (int i = 0; i < 30; i++) begin
            s_vld[i] = (i % 3 != 0) && (i != 17);
            s_in[i]  = rand128();
            s_key[i] = {rand128(), rand128()};
            s_exp[i] = ref_hash(s_key[i], s_in[i]);
        end
        run_seq(30, "R6 bubbles");
    endtask

    // R8: a reset in mid-stream clears the output and drops all in-flight work.
    task automatic t_mid_reset();
        for (int t = 0; t < 15; t++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = rand128();
            in_key   = {rand128(), rand128()};
        end
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        chk(hash_valid == 1'b0, "R8 mid reset valid", 512'(hash_valid), 512'(0));
        chk(hash_out == '0, "R8 mid reset data", hash_out, '0);
        chk(hash_out10 == '0, "R8 mid reset data (10)", hash_out10, '0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        for (int t = 0; t < LAT_A + 4; t++) begin
            @(negedge clk);
            chk(hash_valid == 1'b0, "R8 flushed valid", 512'(hash_valid), 512'(0));
            chk(hash_valid10 == 1'b0, "R8 flushed valid (10)", 512'(hash_valid10), 512'(0));
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_key = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        in_valid = 1'b1;
        t_reset_state();
        in_valid = 1'b0;
        rst_n = 1'b1;
        go_idle(2);
        t_single();
        t_extremes();
        t_stream();
        t_bubbles();
        t_mid_reset();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tot++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

endmodule